// File: doc/BRIEF.md
# Paged 32-bit Register Access over MDIO Commands

This block lets a local requester read and write 32-bit registers inside an attached device that can only be reached through 16-bit management transactions. A request carries a direction, a 16-bit byte address and, for writes, 32 bits of data. The block turns each request into three management commands, one after another, and hands them to the command port of a separate MDIO master. The block never drives the management wires itself.

Every command goes to the same device address. The first command selects a page from the upper address bits. The second moves the lower data half through a register picked by the middle address bits. The third moves the upper half through one fixed register. For a read, the two returned halves are joined into one 32-bit word. The block accepts one request at a time. It acknowledges the request with a single-cycle pulse once the last command has finished.

Top module: `mdio_wide_reg_seq`

## Requirements
- R1: Every command presented on the command port carries device address `cmd_phy` = 5'h1F.
- R2: The first command of each request is a write (`cmd_write`=1) to register 5'h1F whose data is the 10-bit page `req_addr[15:6]`, zero-extended to 16 bits. It is a write whether the request reads or writes.
- R3: The second command targets register {1'b0, `req_addr[5:2]`}. For a write request it is a write of `req_wdata[15:0]`. For a read request it is a read (`cmd_write`=0) with `cmd_wdata` = 0. Address bits [1:0] have no effect.
- R4: The third command targets register 5'h10. For a write request it is a write of `req_wdata[31:16]`. For a read request it is a read with `cmd_wdata` = 0.
- R5: A command is held on the port, with its fields stable, until `cmd_ready` is sampled high. `cmd_valid` then stays low until the matching `cmd_done`. The next command appears in the cycle after that `cmd_done`.
- R6: `req_ack` rises in the cycle after the `cmd_done` of the third command and lasts exactly one cycle. Each accepted request produces exactly one acknowledge.
- R7: For a read, `req_rdata` in the acknowledge cycle equals {data returned by the third command, data returned by the second command}.
- R8: A request is taken only while no sequence is in progress. `req_valid` seen during a sequence is ignored: it changes no command field and causes no extra command or acknowledge.
- R9: While `rst` is high and in the first cycle after it, `cmd_valid` and `req_ack` are low.

Ports are listed in the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | Byte address of the 32-bit register |
| req_wdata | input | 32 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read result, valid with req_ack |
| cmd_valid | output | 1 | Command offered to the MDIO master |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_write | output | 1 | 1 = write command, 0 = read command |
| cmd_phy | output | 5 | Device address of the command |
| cmd_reg | output | 5 | Register number of the command |
| cmd_wdata | output | 16 | Command write data |
| cmd_done | input | 1 | Master finished the accepted command |
| cmd_rdata | input | 16 | Read data from the master, valid with cmd_done |

## Verification
The request is sampled on the edge after it is driven. The first command appears one cycle later. Each following command appears exactly one cycle after the `cmd_done` of the previous one, and `req_ack` with the merged read word comes one cycle after the last `cmd_done`. The bench models the MDIO master. It waits a random number of cycles before ready and before done, and checks every result at the falling edge of that exact cycle. It also checks that `cmd_valid` stays up while waiting for ready and stays down while waiting for done. A second, different request is held on the request port during some sequences to show it has no effect.

// File: rtl/mdio_wide_reg_pkg.sv
package mdio_wide_reg_pkg;

    localparam int DATA_W   = 32;
    localparam int HALF_W   = DATA_W / 2;
    localparam int PHY_W    = 5;
    localparam int REG_W    = 5;
    localparam int PAGE_LSB = 6;
    localparam int PAGE_W   = 10;
    localparam int SEL_LSB  = 2;
    localparam int SEL_W    = 4;
    localparam int ADDR_W   = PAGE_LSB + PAGE_W;

    typedef enum logic [1:0] {
        ST_PAGE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2,
        PH_ACK   = 2'd3
    } phase_e;

    typedef struct packed {
        logic              is_write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    typedef struct packed {
        logic              is_write;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regnum;
        logic [HALF_W-1:0] wdata;
    } mdio_cmd_t;

    function automatic step_e step_after(step_e s);
        case (s)
            ST_PAGE: return ST_LOW;
            ST_LOW:  return ST_HIGH;
            default: return ST_HIGH;
        endcase
    endfunction

    function automatic mdio_cmd_t form_cmd(
        step_e            s,
        xfer_t            x,
        logic [PHY_W-1:0] dev_phy,
        logic [REG_W-1:0] page_reg,
        logic [REG_W-1:0] high_reg
    );
        mdio_cmd_t c;
        c.phy = dev_phy;
        case (s)
            ST_PAGE: begin
                c.is_write = 1'b1;
                c.regnum   = page_reg;
                c.wdata    = HALF_W'(x.addr[PAGE_LSB +: PAGE_W]);
            end
            ST_LOW: begin
                c.is_write = x.is_write;
                c.regnum   = REG_W'(x.addr[SEL_LSB +: SEL_W]);
                c.wdata    = x.is_write ? x.wdata[HALF_W-1:0] : '0;
            end
            default: begin
                c.is_write = x.is_write;
                c.regnum   = high_reg;
                c.wdata    = x.is_write ? x.wdata[DATA_W-1:HALF_W] : '0;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mdio_wide_req_hold.sv
module mdio_wide_req_hold
    import mdio_wide_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  xfer_t req_in,
    output xfer_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held <= req_in;
        end
    end
endmodule

// File: rtl/mdio_wide_step_fsm.sv
module mdio_wide_step_fsm
    import mdio_wide_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  logic  cmd_ready,
    input  logic  cmd_done,
    output logic  load,
    output logic  issue,
    output logic  ack,
    output logic  cap_low,
    output logic  cap_high,
    output step_e step
);
    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= ST_PAGE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase <= PH_ISSUE;
                        step  <= ST_PAGE;
                    end
                end
                PH_ISSUE: begin
                    if (cmd_ready) begin
                        phase <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (cmd_done) begin
                        if (step == ST_HIGH) begin
                            phase <= PH_ACK;
                        end else begin
                            phase <= PH_ISSUE;
                            step  <= step_after(step);
                        end
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        load     = (phase == PH_IDLE) && req_valid;
        issue    = (phase == PH_ISSUE);
        ack      = (phase == PH_ACK);
        cap_low  = (phase == PH_WAIT) && cmd_done && (step == ST_LOW);
        cap_high = (phase == PH_WAIT) && cmd_done && (step == ST_HIGH);
    end
endmodule

// File: rtl/mdio_wide_rd_merge.sv
module mdio_wide_rd_merge
    import mdio_wide_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_low,
    input  logic              cap_high,
    input  logic [HALF_W-1:0] half_in,
    output logic [DATA_W-1:0] word_out
);
    localparam int N_HALVES = DATA_W / HALF_W;

    logic [N_HALVES-1:0] cap_vec;
    assign cap_vec = {cap_high, cap_low};

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                word_out[h*HALF_W +: HALF_W] <= '0;
            end else if (cap_vec[h]) begin
                word_out[h*HALF_W +: HALF_W] <= half_in;
            end
        end
    end
endmodule

// File: rtl/mdio_wide_reg_seq.sv
module mdio_wide_reg_seq
    import mdio_wide_reg_pkg::*;
#(
    parameter logic [PHY_W-1:0] DEV_PHY_ADDR = 5'h1F,
    parameter logic [REG_W-1:0] PAGE_REG_NUM = 5'h1F,
    parameter logic [REG_W-1:0] HIGH_REG_NUM = 5'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [PHY_W-1:0]  cmd_phy,
    output logic [REG_W-1:0]  cmd_reg,
    output logic [HALF_W-1:0] cmd_wdata,
    input  logic              cmd_done,
    input  logic [HALF_W-1:0] cmd_rdata
);
    xfer_t     req_in;
    xfer_t     held;
    mdio_cmd_t cur_cmd;
    step_e     step;
    logic      load, issue, cap_low, cap_high;

    assign req_in = '{is_write: req_write, addr: req_addr, wdata: req_wdata};

    mdio_wide_req_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .req_in (req_in),
        .held   (held)
    );

    mdio_wide_step_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .cmd_ready (cmd_ready),
        .cmd_done  (cmd_done),
        .load      (load),
        .issue     (issue),
        .ack       (req_ack),
        .cap_low   (cap_low),
        .cap_high  (cap_high),
        .step      (step)
    );

    mdio_wide_rd_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .cap_low  (cap_low),
        .cap_high (cap_high),
        .half_in  (cmd_rdata),
        .word_out (req_rdata)
    );

    always_comb begin
        cur_cmd   = form_cmd(step, held, DEV_PHY_ADDR, PAGE_REG_NUM, HIGH_REG_NUM);
        cmd_valid = issue;
        cmd_write = cur_cmd.is_write;
        cmd_phy   = cur_cmd.phy;
        cmd_reg   = cur_cmd.regnum;
        cmd_wdata = cur_cmd.wdata;
    end
endmodule

// File: rtl/mdio_wide_reg_seq_chk.sv
module mdio_wide_reg_seq_chk
    import mdio_wide_reg_pkg::*;
#(
    parameter logic [PHY_W-1:0] DEV_PHY_ADDR = 5'h1F
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ack,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_write,
    input logic [PHY_W-1:0]  cmd_phy,
    input logic [REG_W-1:0]  cmd_reg,
    input logic [HALF_W-1:0] cmd_wdata,
    input logic              cmd_done
);
    logic       outstanding;
    logic [1:0] cmd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            cmd_cnt     <= '0;
        end else begin
            if (cmd_valid && cmd_ready) begin
                outstanding <= 1'b1;
            end else if (cmd_done) begin
                outstanding <= 1'b0;
            end
            if (req_ack) begin
                cmd_cnt <= '0;
            end else if (cmd_valid && cmd_ready) begin
                cmd_cnt <= cmd_cnt + 2'd1;
            end
        end
    end

    p_fixed_phy_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_phy == DEV_PHY_ADDR));

    p_three_cmds_r2: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> (cmd_cnt == 2'd3));

    p_hold_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_reg) &&
                                       $stable(cmd_wdata) && $stable(cmd_write)));

    p_one_outstanding_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !outstanding);

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    p_ack_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ack) |-> $past(cmd_done));

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!cmd_valid && !req_ack));
endmodule

bind mdio_wide_reg_seq mdio_wide_reg_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ack   (req_ack),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .cmd_phy   (cmd_phy),
    .cmd_reg   (cmd_reg),
    .cmd_wdata (cmd_wdata),
    .cmd_done  (cmd_done)
);

// File: tb/mdio_wide_reg_seq_tb.sv
`timescale 1ns/1ps
module mdio_wide_reg_seq_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        req_ack;
    logic [31:0] req_rdata;
    logic        cmd_valid, cmd_ready, cmd_write, cmd_done;
    logic [4:0]  cmd_phy, cmd_reg;
    logic [15:0] cmd_wdata, cmd_rdata;

    int vectors = 0;
    int errors  = 0;
    logic [9:0] page_seen = '0;

    always #4 clk = ~clk;

    mdio_wide_reg_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .req_rdata(req_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata)
    );

    function automatic logic [15:0] dev_word(logic [9:0] page, logic [4:0] rn);
        logic [15:0] p = {6'b0, page};
        logic [15:0] r = {11'b0, rn};
        return (p * 16'd37) ^ (r * 16'h0101) ^ 16'hA5C3;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_access(bit wr, logic [15:0] addr, logic [31:0] wd,
                             bit hold_req, int rdy_max, int done_max);
        logic [4:0]  exp_reg[3];
        logic [15:0] exp_dat[3];
        logic        exp_wr[3];
        logic [31:0] exp_rd;
        exp_reg[0] = 5'h1F; exp_wr[0] = 1'b1; exp_dat[0] = {6'b0, addr[15:6]};
        exp_reg[1] = {1'b0, addr[5:2]}; exp_wr[1] = wr; exp_dat[1] = wr ? wd[15:0]  : 16'h0;
        exp_reg[2] = 5'h10;             exp_wr[2] = wr; exp_dat[2] = wr ? wd[31:16] : 16'h0;
        exp_rd = {dev_word(addr[15:6], 5'h10), dev_word(addr[15:6], {1'b0, addr[5:2]})};

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        if (hold_req) begin
            req_write = ~wr; req_addr = ~addr; req_wdata = ~wd;   // R8 busy request
        end else begin
            req_valid = 1'b0;
        end
        for (int k = 0; k < 3; k++) begin
            int guard = 0;
            int d;
            while (!cmd_valid && guard < 40) begin
                @(negedge clk);
                guard++;
            end
            chk("R5 command offered", {31'b0, cmd_valid}, 32'd1);
            chk("R1 device address", {27'b0, cmd_phy}, 32'h1F);
            if (k == 0) begin
                chk("R2 page reg", {27'b0, cmd_reg}, {27'b0, exp_reg[k]});
                chk("R2 page write", {31'b0, cmd_write}, {31'b0, exp_wr[k]});
                chk("R2 page data", {16'b0, cmd_wdata}, {16'b0, exp_dat[k]});
            end else if (k == 1) begin
                chk("R3 low reg", {27'b0, cmd_reg}, {27'b0, exp_reg[k]});
                chk("R3 low dir", {31'b0, cmd_write}, {31'b0, exp_wr[k]});
                chk("R3 low data", {16'b0, cmd_wdata}, {16'b0, exp_dat[k]});
            end else begin
                chk("R4 high reg", {27'b0, cmd_reg}, {27'b0, exp_reg[k]});
                chk("R4 high dir", {31'b0, cmd_write}, {31'b0, exp_wr[k]});
                chk("R4 high data", {16'b0, cmd_wdata}, {16'b0, exp_dat[k]});
            end
            d = (rdy_max > 0) ? int'($urandom_range(rdy_max, 0)) : 0;
            repeat (d) begin
                @(negedge clk);
                chk("R5 held until ready", {26'b0, cmd_valid, cmd_reg},
                    {26'b0, 1'b1, exp_reg[k]});
            end
            if (cmd_write && cmd_reg == 5'h1F) page_seen = cmd_wdata[9:0];
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            chk("R5 dropped after accept", {31'b0, cmd_valid}, 32'd0);
            d = int'($urandom_range(done_max, 1)) - 1;
            repeat (d) begin
                @(negedge clk);
                chk("R5 quiet while waiting", {31'b0, cmd_valid}, 32'd0);
            end
            cmd_done  = 1'b1;
            cmd_rdata = exp_wr[k] ? 16'h0 : dev_word(page_seen, exp_reg[k]);
            @(negedge clk);
            cmd_done  = 1'b0;
            cmd_rdata = 16'hxxxx;
            if (k < 2) begin
                chk("R5 next command after done", {30'b0, cmd_valid, req_ack}, 32'd2);
            end else begin
                chk("R6 ack after last done", {31'b0, req_ack}, 32'd1);
                if (!wr) chk("R7 merged read", req_rdata, exp_rd);
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R6 single-cycle ack", {31'b0, req_ack}, 32'd0);
        repeat (2) begin
            @(negedge clk);
            chk("R8 no extra activity", {30'b0, cmd_valid, req_ack}, 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        int unsigned seed_init;
        seed_init = $urandom(32'd7041);
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; cmd_ready = 1'b0; cmd_done = 1'b0; cmd_rdata = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset outputs", {30'b0, cmd_valid, req_ack}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 after reset", {30'b0, cmd_valid, req_ack}, 32'd0);

        // directed corners
        do_access(1'b1, 16'hFFFF, 32'hFFFF_0000, 1'b0, 0, 1);
        do_access(1'b0, 16'hFFFF, 32'h0,         1'b0, 0, 1);
        do_access(1'b1, 16'h0000, 32'h1234_5678, 1'b0, 3, 4);
        do_access(1'b0, 16'h0000, 32'h0,         1'b0, 3, 4);
        do_access(1'b0, 16'h7ABF, 32'h0,         1'b1, 2, 3);   // R3 low bits [1:0]=3, R8
        do_access(1'b1, 16'h0043, 32'hDEAD_BEEF, 1'b1, 1, 2);   // R8 busy request held

        for (int i = 0; i < 40; i++) begin
            do_access(1'($urandom_range(1, 0)), 16'($urandom), $urandom,
                      1'($urandom_range(1, 0)), 3, 4);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule